// File: doc/BRIEF.md
# Line-Code Error Injection Controller

This block sits beside the bipolar line encoder of a T3/E3 transmitter and produces per-cycle test-error commands: force a bipolar violation on the current mark, suppress the zero-substitution code word that the encoder would otherwise insert, or invert both P bits of a T3 frame. Each error type has its own enable input. In automatic mode, a rising edge of an enable arms that type once. The error then goes out at the next line or frame event that suits it.

In manual mode, the enables only select which types are eligible. Every toggle of an asynchronous trigger pin, after synchronisation, arms each selected type once. The block watches the transmit data itself to find runs of ones and the points where substitution would occur. The threshold for those points follows the T3/E3 selection. The framer supplies a frame-start strobe and a strobe for each P-bit position. Each insertion also raises a one-cycle pulse on a per-type "inserted" output.

Top module: `line_err_inject`

## Requirements
- R1: While rst_ni is low, all six outputs are low.
- R2: In automatic mode (manual_mode_i = 0), a type is armed only on a 0-to-1 change of its enable. Each arm yields exactly one insertion, and the enable must go low and then high again before another insertion.
- R3: An armed violation is commanded (force_bpv_o = 1) in the cycle in which data_i carries the third or a later consecutive 1.
- R4: Zeros are counted from the last 1 or from the last substitution point. The point is the zero that brings the count to 3 in T3 mode (e3_mode_i = 0) or to 4 in E3 mode. An armed excessive-zero request drives suppress_sub_o = 1 at the next such point.
- R5: An armed parity request waits for the next frame_start_i. It then drives invert_p_o = 1 on the first two pbit_i cycles that follow. A request armed mid-frame skips that frame's P bits.
- R6: With unipolar_i = 1, the violation and excessive-zero types never fire, and requests that are already pending are discarded.
- R7: With e3_mode_i = 1, the parity type never fires, and a pending parity request is discarded.
- R8: In manual mode, each edge of trig_i, rising or falling, is passed through a two-flop synchroniser. It then arms every type whose enable is high, and arms no type whose enable is low.
- R9: An arm that arrives while the same type is still pending is ignored and does not queue a second insertion.
- R10: ins_bpv_o and ins_exz_o pulse for one cycle with each violation or suppression. ins_par_o pulses once, on the second inverted P bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bpv_en_i | input | 1 | Violation type enable |
| exz_en_i | input | 1 | Excessive-zero type enable |
| par_en_i | input | 1 | P-bit parity type enable |
| manual_mode_i | input | 1 | 1 = arm on trigger toggles, 0 = arm on enable rising edges |
| trig_i | input | 1 | Asynchronous manual trigger |
| e3_mode_i | input | 1 | 1 = E3 line, 0 = T3 line |
| unipolar_i | input | 1 | 1 = unipolar interface, no line coding |
| data_i | input | 1 | Transmit data bit for this cycle |
| frame_start_i | input | 1 | Frame start strobe |
| pbit_i | input | 1 | Strobe for a P-bit position |
| force_bpv_o | output | 1 | Command: send a violation on this bit |
| suppress_sub_o | output | 1 | Command: skip the substitution code word at this bit |
| invert_p_o | output | 1 | Command: invert this P bit |
| ins_bpv_o | output | 1 | Violation inserted pulse |
| ins_exz_o | output | 1 | Excessive-zero inserted pulse |
| ins_par_o | output | 1 | Parity error completed pulse |

## Verification
A violation and a P-bit inversion can be commanded in the same cycle, because a P-bit slot can carry the third 1 of a run. The bench arms the parity type one cycle before a frame start and arms the violation type on that start. It then places three 1s so that the third one falls on the first P bit. Both commands must be high in that single cycle. In the next P-bit cycle only the inversion and the parity pulse may appear. A second overlap, where one manual toggle arms both the violation and the excessive-zero types, is judged by counting exactly one of each over the following ones-then-zeros pattern.

// File: rtl/lei_pkg.sv
package lei_pkg;
  typedef enum logic [1:0] {
    K_BPV = 2'd0,
    K_EXZ = 2'd1,
    K_PAR = 2'd2
  } err_kind_e;
  localparam int NUM_KINDS = 3;
endpackage

// File: rtl/lei_sync.sv
module lei_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic tog_o
);
  // sh[STAGES-1:0] synchroniser, sh[STAGES] history for edge detect
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign tog_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/lei_arm.sv
module lei_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic manual_i,
  input  logic tog_i,
  input  logic allow_i,
  input  logic fire_i,
  output logic pend_o
);
  logic en_q, pend_q, arm;

  assign arm = manual_i ? (tog_i & en_i) : (en_i & ~en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!allow_i)    pend_q <= 1'b0;
      else if (fire_i) pend_q <= 1'b0;
      else if (arm)    pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  // R9: a pending request survives until fired or disallowed
  a_r9_pend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && allow_i && !fire_i |=> pend_q);
  // R2: arming only with the enable high
  a_r2_arm_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(en_i && allow_i));
endmodule

// File: rtl/lei_line_mon.sv
module lei_line_mon #(
  parameter int T3_THR   = 3,
  parameter int E3_THR   = 4,
  parameter int ONES_RUN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic e3_i,
  output logic run_o,
  output logic zopp_o
);
  localparam int ZW = $clog2(E3_THR + 1);
  localparam int OW = $clog2(ONES_RUN);
  localparam logic [OW-1:0] ONES_MAX = OW'(ONES_RUN - 1);

  logic [ZW-1:0] zeros_q, thr_m1;
  logic [OW-1:0] ones_q;

  assign thr_m1 = e3_i ? ZW'(E3_THR - 1) : ZW'(T3_THR - 1);
  assign zopp_o = ~data_i & (zeros_q >= thr_m1);
  assign run_o  = data_i & (ones_q == ONES_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zeros_q <= '0;
      ones_q  <= '0;
    end else begin
      if (data_i || zopp_o) zeros_q <= '0;
      else                  zeros_q <= zeros_q + 1'b1;
      if (!data_i)                ones_q <= '0;
      else if (ones_q != ONES_MAX) ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/lei_par_seq.sv
module lei_par_seq #(
  parameter int PBITS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic allow_i,
  input  logic fs_i,
  input  logic pb_i,
  output logic take_o,
  output logic inv_o,
  output logic done_o
);
  localparam int PW = (PBITS > 1) ? $clog2(PBITS) : 1;

  logic          act_q;
  logic [PW-1:0] pcnt_q;

  assign take_o = pend_i & allow_i & fs_i & ~act_q;
  assign inv_o  = act_q & allow_i & pb_i;
  assign done_o = inv_o & (pcnt_q == PW'(PBITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pcnt_q <= '0;
    end else if (!allow_i) begin
      act_q  <= 1'b0;
      pcnt_q <= '0;
    end else if (take_o) begin
      act_q  <= 1'b1;
      pcnt_q <= '0;
    end else if (done_o) begin
      act_q  <= 1'b0;
      pcnt_q <= '0;
    end else if (inv_o) begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R5: a frame is only entered on a frame start
  a_r5_act_on_fs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(fs_i));
  // R5: sequence closes after the last P bit
  a_r5_done_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !act_q);
endmodule

// File: rtl/line_err_inject.sv
module line_err_inject
  import lei_pkg::*;
#(
  parameter int T3_THR      = 3,
  parameter int E3_THR      = 4,
  parameter int ONES_RUN    = 3,
  parameter int PBITS       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bpv_en_i,
  input  logic exz_en_i,
  input  logic par_en_i,
  input  logic manual_mode_i,
  input  logic trig_i,
  input  logic e3_mode_i,
  input  logic unipolar_i,
  input  logic data_i,
  input  logic frame_start_i,
  input  logic pbit_i,
  output logic force_bpv_o,
  output logic suppress_sub_o,
  output logic invert_p_o,
  output logic ins_bpv_o,
  output logic ins_exz_o,
  output logic ins_par_o
);
  logic                 tog, run3, zopp, take, inv, done;
  logic [NUM_KINDS-1:0] en, allow, fire, pend;

  lei_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(trig_i), .tog_o(tog));

  lei_line_mon #(.T3_THR(T3_THR), .E3_THR(E3_THR), .ONES_RUN(ONES_RUN)) u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .e3_i(e3_mode_i),
    .run_o(run3), .zopp_o(zopp));

  assign en[int'(K_BPV)]    = bpv_en_i;
  assign en[int'(K_EXZ)]    = exz_en_i;
  assign en[int'(K_PAR)]    = par_en_i;
  assign allow[int'(K_BPV)] = ~unipolar_i;
  assign allow[int'(K_EXZ)] = ~unipolar_i;
  assign allow[int'(K_PAR)] = ~e3_mode_i;

  assign fire[int'(K_BPV)] = pend[int'(K_BPV)] & allow[int'(K_BPV)] & run3;
  assign fire[int'(K_EXZ)] = pend[int'(K_EXZ)] & allow[int'(K_EXZ)] & zopp;
  assign fire[int'(K_PAR)] = take;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_arm
    lei_arm u_arm (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en[k]), .manual_i(manual_mode_i),
      .tog_i(tog), .allow_i(allow[k]), .fire_i(fire[k]), .pend_o(pend[k]));
  end

  lei_par_seq #(.PBITS(PBITS)) u_par (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend[int'(K_PAR)]),
    .allow_i(allow[int'(K_PAR)]), .fs_i(frame_start_i), .pb_i(pbit_i),
    .take_o(take), .inv_o(inv), .done_o(done));

  assign force_bpv_o    = fire[int'(K_BPV)];
  assign suppress_sub_o = fire[int'(K_EXZ)];
  assign invert_p_o     = inv;
  assign ins_bpv_o      = fire[int'(K_BPV)];
  assign ins_exz_o      = fire[int'(K_EXZ)];
  assign ins_par_o      = done;

  a_r6_unipolar_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unipolar_i |-> !force_bpv_o && !suppress_sub_o);
  a_r7_e3_no_invert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e3_mode_i |-> !invert_p_o);
  a_r3_bpv_on_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_bpv_o |-> data_i && $past(data_i) && $past(data_i, 2));
  a_r4_sup_on_zeros: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_sub_o |-> !data_i && !$past(data_i) && !$past(data_i, 2));
  a_r10_par_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_par_o |=> !ins_par_o);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> !force_bpv_o && !suppress_sub_o && !invert_p_o);
endmodule

// File: tb/line_err_inject_tb_top.sv
`timescale 1ns/1ps
module line_err_inject_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bpv_en = 0, exz_en = 0, par_en = 0, manual = 0, trig = 0;
  logic e3 = 0, unip = 0, data = 0, fs = 0, pb = 0;
  logic f_bpv, s_sub, i_p, ins_b, ins_e, ins_p;
  int   errors = 0, checks = 0;
  int   n_b = 0, n_s = 0, n_i = 0, n_ib = 0, n_ie = 0, n_ip = 0;

  always #2.5 clk = ~clk;

  line_err_inject dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bpv_en_i(bpv_en), .exz_en_i(exz_en),
    .par_en_i(par_en), .manual_mode_i(manual), .trig_i(trig),
    .e3_mode_i(e3), .unipolar_i(unip), .data_i(data),
    .frame_start_i(fs), .pbit_i(pb), .force_bpv_o(f_bpv),
    .suppress_sub_o(s_sub), .invert_p_o(i_p), .ins_bpv_o(ins_b),
    .ins_exz_o(ins_e), .ins_par_o(ins_p));

  // {bpv_en, exz_en, par_en, data, fs, pb, exp_bpv, exp_sup, exp_inv}
  localparam int NV = 22;
  localparam logic [8:0] TBL [NV] = '{
    9'b000_000_000, 9'b100_100_000, 9'b100_100_000, 9'b100_100_100,
    9'b100_100_000, 9'b100_000_000, 9'b110_000_000, 9'b110_000_010,
    9'b110_000_000, 9'b110_000_000, 9'b110_000_000, 9'b111_000_000,
    9'b111_001_000, 9'b111_010_000, 9'b111_001_001, 9'b111_000_000,
    9'b111_001_001, 9'b111_010_000, 9'b111_001_000, 9'b011_100_000,
    9'b111_100_000, 9'b111_100_100};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_b = 0; n_s = 0; n_i = 0; n_ib = 0; n_ie = 0; n_ip = 0;
  endtask

  task automatic tick(input logic d, input logic f, input logic p);
    @(negedge clk);
    data = d; fs = f; pb = p;
    #2;
    n_b += int'(f_bpv); n_s += int'(s_sub); n_i += int'(i_p);
    n_ib += int'(ins_b); n_ie += int'(ins_e); n_ip += int'(ins_p);
  endtask

  task automatic alt(input int n);
    for (int i = 0; i < n; i++) tick(i[0], 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    data = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 force", int'(f_bpv), 0);
    chk("R1 sup", int'(s_sub), 0);
    chk("R1 inv", int'(i_p), 0);
    chk("R1 ins", int'(ins_b | ins_e | ins_p), 0);
    @(negedge clk); rst_n = 1'b1; data = 1'b0;

    // R2 R3 R4 R5 table walk, T3 bipolar automatic
    for (int v = 0; v < NV; v++) begin
      bpv_en = TBL[v][8]; exz_en = TBL[v][7]; par_en = TBL[v][6];
      tick(TBL[v][5], TBL[v][4], TBL[v][3]);
      chk($sformatf("R3 bpv row %0d", v), int'(f_bpv), int'(TBL[v][2]));
      chk($sformatf("R4 sup row %0d", v), int'(s_sub), int'(TBL[v][1]));
      chk($sformatf("R5 inv row %0d", v), int'(i_p), int'(TBL[v][0]));
    end
    bpv_en = 0; exz_en = 0; par_en = 0;
    alt(4);

    // R6 unipolar: arms and pending requests have no effect
    unip = 1; clr();
    bpv_en = 1; exz_en = 1;
    repeat (4) tick(1, 0, 0);
    repeat (4) tick(0, 0, 0);
    chk("R6 bpv unipolar", n_b, 0);
    chk("R6 sup unipolar", n_s, 0);
    unip = 0;
    repeat (4) tick(1, 0, 0);
    repeat (4) tick(0, 0, 0);
    chk("R6 bpv discarded", n_b, 0);
    chk("R6 sup discarded", n_s, 0);
    bpv_en = 0; exz_en = 0;
    alt(4);

    // R4 E3 threshold of four zeros
    e3 = 1; clr();
    exz_en = 1;
    repeat (2) tick(1, 0, 0);
    repeat (3) tick(0, 0, 0);
    chk("R4 e3 three zeros", n_s, 0);
    tick(0, 0, 0);
    chk("R4 e3 fourth zero", int'(s_sub), 1);
    chk("R10 ins_exz", n_ie, 1);
    exz_en = 0;

    // R7 E3 parity ignored
    clr(); par_en = 1;
    tick(0, 0, 0); tick(0, 1, 0); tick(0, 0, 1); tick(0, 0, 1);
    tick(0, 1, 0); tick(0, 0, 1); tick(0, 0, 1);
    chk("R7 e3 parity", n_i, 0);
    par_en = 0; e3 = 0;
    alt(4);

    // R9 re-arm while pending does not queue
    clr();
    bpv_en = 1; tick(0, 0, 0);
    bpv_en = 0; tick(0, 0, 0);
    bpv_en = 1; tick(0, 0, 0);
    repeat (6) tick(1, 0, 0);
    chk("R9 single insertion", n_b, 1);
    bpv_en = 0;
    alt(4);

    // R8 manual mode
    manual = 1; bpv_en = 1; clr();
    repeat (5) tick(1, 0, 0);
    chk("R8 no toggle", n_b, 0);
    alt(6);
    trig = 1; alt(6); clr();
    repeat (4) tick(1, 0, 0);
    chk("R8 rising toggle", n_b, 1);
    trig = 0; alt(6); clr();
    repeat (4) tick(1, 0, 0);
    chk("R8 falling toggle", n_b, 1);
    bpv_en = 0; trig = 1; alt(6); clr();
    repeat (4) tick(1, 0, 0);
    repeat (4) tick(0, 0, 0);
    chk("R8 disabled bpv", n_b, 0);
    chk("R8 disabled exz", n_s, 0);
    bpv_en = 1; exz_en = 1; alt(2);
    trig = 0; alt(6); clr();
    repeat (3) tick(1, 0, 0);
    repeat (3) tick(0, 0, 0);
    chk("R8 both bpv", n_b, 1);
    chk("R8 both exz", n_s, 1);
    bpv_en = 0; exz_en = 0; alt(2);
    manual = 0;
    alt(4);

    // R5 R3 R10 coincidence of violation and P-bit inversion
    clr();
    par_en = 1; tick(0, 0, 0);
    bpv_en = 1; tick(1, 1, 0);
    tick(1, 0, 0);
    chk("R5 no early inv", n_i, 0);
    tick(1, 0, 1);
    chk("R3 coincident force", int'(f_bpv), 1);
    chk("R5 coincident inv", int'(i_p), 1);
    chk("R10 no early ins_par", int'(ins_p), 0);
    tick(1, 0, 1);
    chk("R5 second inv", int'(i_p), 1);
    chk("R10 ins_par on second", int'(ins_p), 1);
    chk("R2 bpv once", int'(f_bpv), 0);
    tick(0, 0, 1);
    chk("R5 third pbit clear", int'(i_p), 0);
    chk("R10 ins_bpv count", n_ib, 1);
    bpv_en = 0; par_en = 0;
    alt(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule